// File: doc/BRIEF.md
# Push-Button Message Transmitter over UART

This block sends a fixed sixteen-byte text message on an asynchronous serial line each time a push button goes from released to pressed. The message sits in a small read-only table inside the block. A controller walks the table from the first entry to the last. For each byte it sends one frame: a low start bit, eight data bits with the least significant bit first, and a high stop bit. No parity bit is sent. When the last byte has gone out, the controller goes back to waiting for the next press.

A counter sets the bit period. It counts clock cycles from zero up to a terminal value and then wraps to zero. The terminal value comes from the clock-frequency and baud-rate parameters. The controller is split into three parts: a state register, next-state logic and output-forming logic. It steers a three-way output selector: a constant low for the start bit, the serial output of a parallel-load shift register for the data bits, and a constant high for the stop bit and idle. A second output carries the same line to a test header.

Top module: `uart_msg_tx`

## Requirements
- R1: After reset, and whenever no message is in progress, the serial line is high.
- R2: A low-to-high change of the button starts exactly one message. Holding the button high after a message ends does not start another one.
- R3: Each frame begins with a start bit that is low for one bit time.
- R4: Each frame carries eight data bits after its start bit, least significant bit first. Each data bit lasts one bit time.
- R5: Each frame ends with a stop bit that is high for one bit time.
- R6: One message is sixteen frames, carrying the ASCII bytes of "HELLO FROM ROM" followed by carriage return (0x0D) and line feed (0x0A), in table order starting at entry 0. The next frame follows each stop bit with no gap.
- R7: One bit time is exactly CLK_FREQ/BAUD clock cycles, integer division. The period counter runs from 0 to CLK_FREQ/BAUD-1 and wraps to 0.
- R8: Button activity while a message is in progress has no effect. The message goes on in order, and no second message follows it.
- R9: The test-header output always equals the serial line output.
- R10: An active-low synchronous reset taken in the middle of a message returns the line to high at the next clock edge. The message does not resume after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| btn | input | 1 | Push button, asynchronous, active high |
| tx_out | output | 1 | UART serial transmit line |
| probe_out | output | 1 | Copy of the transmit line for a test header |

## Verification
The bench decodes every frame of a message at mid-bit. It checks the byte order and the bit order, so a design that sends the most significant bit first, skips the last data bit or fails to advance the table address produces wrong characters. It measures the leading low run of the first frame in clock cycles: the start bit plus three zero data bits. An off-by-one terminal count changes that length. It pulses the button during a message and holds the button after the message. A design without edge detection would restart or repeat the message. It also resets in the middle of a frame, which exposes a line that stays low or a message that resumes.

// File: rtl/uart_msg_pkg.sv
// Shared definitions for the message transmitter.
// Assumes a fixed sixteen-entry message of eight-bit characters.
package uart_msg_pkg;

    localparam int MSG_AW = 4;
    localparam int MSG_DW = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } tx_state_e;

    // Message contents: "HELLO FROM ROM" then CR LF.
    function automatic logic [MSG_DW-1:0] msg_byte(input logic [MSG_AW-1:0] a);
        logic [MSG_DW-1:0] b;
        case (a)
            4'd0:  b = 8'h48;
            4'd1:  b = 8'h45;
            4'd2:  b = 8'h4C;
            4'd3:  b = 8'h4C;
            4'd4:  b = 8'h4F;
            4'd5:  b = 8'h20;
            4'd6:  b = 8'h46;
            4'd7:  b = 8'h52;
            4'd8:  b = 8'h4F;
            4'd9:  b = 8'h4D;
            4'd10: b = 8'h20;
            4'd11: b = 8'h52;
            4'd12: b = 8'h4F;
            4'd13: b = 8'h4D;
            4'd14: b = 8'h0D;
            default: b = 8'h0A;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/uart_msg_rom.sv
// Combinational message table.
// Assumes the address and data widths match the package constants.
module uart_msg_rom
    import uart_msg_pkg::*;
(
    input  logic [MSG_AW-1:0] addr,
    output logic [MSG_DW-1:0] data
);

    // Table lookup.
    always_comb begin
        data = msg_byte(addr);
    end

endmodule

// File: rtl/uart_baud_cnt.sv
// Free-running bit-period counter. It counts 0..TC and wraps to zero.
// A synchronous clear holds it at zero. Assumes TC >= 1.
module uart_baud_cnt #(
    parameter int unsigned CNT_W = 10,
    parameter logic [CNT_W-1:0] TC = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);

    // Count with rollover at the terminal value.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (cnt == TC)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/uart_shift_reg.sv
// Parallel-load, right-shift register. The serial output is bit 0.
// Assumes load and shift are never both asserted.
module uart_shift_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic         sout
);

    logic [W-1:0] sr_q;

    // Load a byte or move it one place toward bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sr_q <= '1;
        else if (load)
            sr_q <= din;
        else if (shift)
            sr_q <= {1'b1, sr_q[W-1:1]};
    end

    assign sout = sr_q[0];

endmodule

// File: rtl/uart_msg_tx.sv
// Button-triggered message transmitter. Each rising button edge sends the
// sixteen table bytes as 8N1 frames, least significant bit first.
// Assumes CLK_FREQ/BAUD >= 2. The button is asynchronous and already debounced.
module uart_msg_tx
    import uart_msg_pkg::*;
#(
    parameter int unsigned CLK_FREQ = 100_000_000,
    parameter int unsigned BAUD     = 115_200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn,
    output logic tx_out,
    output logic probe_out
);

    localparam int unsigned DIV   = CLK_FREQ / BAUD;
    localparam int unsigned CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] TC_V = CNT_W'(DIV - 1);
    localparam logic [MSG_AW-1:0] LAST_ADDR = '1;

    tx_state_e         state_q, state_d;
    logic [2:0]        sync_q;
    logic              btn_rise;
    logic [CNT_W-1:0]  baud_cnt;
    logic              tick;
    logic [MSG_AW-1:0] addr_q;
    logic [MSG_DW-1:0] rom_data;
    logic [2:0]        bit_cnt_q;
    logic              sr_out;
    logic              baud_clr, addr_clr, addr_inc, load, shift;

    // Two-stage synchroniser plus an edge-history flop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sync_q <= '0;
        else
            sync_q <= {sync_q[1:0], btn};
    end
    assign btn_rise = sync_q[1] & ~sync_q[2];

    uart_baud_cnt #(.CNT_W(CNT_W), .TC(TC_V)) baud_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (baud_clr),
        .cnt   (baud_cnt)
    );
    assign tick = (baud_cnt == TC_V);

    uart_msg_rom rom_i (
        .addr (addr_q),
        .data (rom_data)
    );

    uart_shift_reg #(.W(MSG_DW)) sr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .shift (shift),
        .din   (rom_data),
        .sout  (sr_out)
    );

    // Message address counter.
    always_ff @(posedge clk) begin
        if (!rst_n || addr_clr)
            addr_q <= '0;
        else if (addr_inc)
            addr_q <= addr_q + 1'b1;
    end

    // Data-bit counter for the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n || load)
            bit_cnt_q <= '0;
        else if (shift)
            bit_cnt_q <= bit_cnt_q + 1'b1;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (btn_rise) state_d = ST_START;
            ST_START: if (tick) state_d = ST_DATA;
            ST_DATA:  if (tick && bit_cnt_q == 3'd7) state_d = ST_STOP;
            ST_STOP:  if (tick) state_d = (addr_q == LAST_ADDR) ? ST_IDLE : ST_START;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Output-forming logic.
    always_comb begin
        baud_clr = (state_q == ST_IDLE);
        addr_clr = (state_q == ST_IDLE) && btn_rise;
        load     = (state_q == ST_START) && tick;
        shift    = (state_q == ST_DATA) && tick && (bit_cnt_q != 3'd7);
        addr_inc = (state_q == ST_STOP) && tick;
    end

    // Line selector: start low, data from the shift register, otherwise high.
    always_comb begin
        case (state_q)
            ST_START: tx_out = 1'b0;
            ST_DATA:  tx_out = sr_out;
            default:  tx_out = 1'b1;
        endcase
    end

    assign probe_out = tx_out;

endmodule

// File: rtl/uart_msg_tx_chk.sv
// Protocol checker for uart_msg_tx. It is attached through bind.
module uart_msg_tx_chk
    import uart_msg_pkg::*;
#(
    parameter int unsigned CNT_W = 10,
    parameter logic [CNT_W-1:0] TC = '1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_out,
    input tx_state_e         st,
    input logic [CNT_W-1:0]  baud_cnt,
    input logic [MSG_AW-1:0] addr
);

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_IDLE |-> tx_out); // R1

    AST_START_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_START |-> !tx_out); // R3

    AST_STOP_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_STOP |-> tx_out); // R5

    AST_DATA_ENDS_ON_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STOP && $past(st) == ST_DATA) |-> $past(baud_cnt) == TC); // R4

    AST_MSG_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_START && $past(st) == ST_IDLE) |-> addr == '0); // R6

    AST_BAUD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        baud_cnt <= TC); // R7

    AST_BAUD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (baud_cnt == TC) |=> baud_cnt == '0); // R7

endmodule

bind uart_msg_tx uart_msg_tx_chk #(.CNT_W(CNT_W), .TC(TC_V)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_out   (tx_out),
    .st       (state_q),
    .baud_cnt (baud_cnt),
    .addr     (addr_q)
);

// File: tb/uart_msg_tx_tb_top.sv
// Self-checking bench for uart_msg_tx. It decodes frames from the line at mid-bit.
module uart_msg_tx_tb_top;

    localparam int unsigned CLK_FREQ = 1_152_000;
    localparam int unsigned BAUD     = 115_200;
    localparam int unsigned DIV      = CLK_FREQ / BAUD;

    // Expected message, one vector per frame.
    localparam logic [7:0] EXP_TAB [0:15] = '{
        8'h48, 8'h45, 8'h4C, 8'h4C, 8'h4F, 8'h20, 8'h46, 8'h52,
        8'h4F, 8'h4D, 8'h20, 8'h52, 8'h4F, 8'h4D, 8'h0D, 8'h0A
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic btn = 1'b0;
    logic tx_out, probe_out;
    int   n_chk = 0;
    int   n_fail = 0;

    always #4 clk = ~clk;

    uart_msg_tx #(.CLK_FREQ(CLK_FREQ), .BAUD(BAUD)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .btn       (btn),
        .tx_out    (tx_out),
        .probe_out (probe_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Decode one frame. Returns byte, start level, stop level and probe mismatches.
    task automatic recv(output logic [7:0] b, output logic st, output logic sp, output int mism);
        mism = 0;
        do @(negedge clk); while (tx_out !== 1'b0);
        repeat (DIV / 2) @(negedge clk);
        st = tx_out;
        if (probe_out !== tx_out) mism++;
        for (int k = 0; k < 8; k++) begin
            repeat (DIV) @(negedge clk);
            b[k] = tx_out;
            if (probe_out !== tx_out) mism++;
        end
        repeat (DIV) @(negedge clk);
        sp = tx_out;
        if (probe_out !== tx_out) mism++;
    endtask

    // Count cycles the line goes low over a window.
    task automatic count_low(input int cycles, output int lows);
        lows = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (tx_out !== 1'b1 || probe_out !== 1'b1) lows++;
        end
    endtask

    initial begin
        repeat (2000 * DIV) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] b;
        logic st, sp;
        int mism, lows, run;

        repeat (4) @(negedge clk);
        chk("R1 reset line level", {31'd0, tx_out}, 32'd1);
        chk("R9 reset probe copy", {31'd0, probe_out}, 32'd1);
        rst_n = 1'b1;
        count_low(3 * DIV, lows);
        chk("R1 idle without press", lows, 0);

        // Message one, with a button pulse during frame 5 (R8).
        btn = 1'b1;
        for (int i = 0; i < 16; i++) begin
            recv(b, st, sp, mism);
            chk($sformatf("R4 R6 frame %0d byte", i), {24'd0, b}, {24'd0, EXP_TAB[i]});
            chk("R3 start bit", {31'd0, st}, 32'd0);
            chk("R5 stop bit", {31'd0, sp}, 32'd1);
            chk("R9 probe follows line", mism, 0);
            if (i == 5) begin
                btn = 1'b0;
                repeat (2) @(negedge clk);
                btn = 1'b1;
            end
        end
        count_low(20 * DIV, lows);
        chk("R2 R8 no second message while held", lows, 0);

        // Message two: leading low run is start + three zero bits of 0x48 (R7).
        btn = 1'b0;
        repeat (4) @(negedge clk);
        btn = 1'b1;
        do @(negedge clk); while (tx_out !== 1'b0);
        run = 0;
        do begin
            @(negedge clk);
            run++;
        end while (tx_out !== 1'b1);
        chk("R7 first low run cycles", run, 4 * DIV);
        repeat (16 * 10 * DIV) @(negedge clk);
        count_low(3 * DIV, lows);
        chk("R1 idle after message", lows, 0);

        // Reset mid-frame (R10).
        btn = 1'b0;
        repeat (4) @(negedge clk);
        btn = 1'b1;
        do @(negedge clk); while (tx_out !== 1'b0);
        repeat (3 * DIV + 2) @(negedge clk);
        rst_n = 1'b0;
        btn = 1'b0;
        @(negedge clk);
        chk("R10 line high after reset", {31'd0, tx_out}, 32'd1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        count_low(12 * DIV, lows);
        chk("R10 no resume after reset", lows, 0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule